// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block collects interrupt requests for a small 8-bit controller core and gives the core one request at a time. There are five sources: two active-low external pins, an overflow flag from each of two timer/counters, and a serial-port flag. Each pin has its own trigger-mode bit. In level mode the request follows the synchronised pin. In falling-edge mode the request is latched until the core accepts that source. Because the pins are active-low, several open-drain devices can share one pin in a wired-OR arrangement.

Each source has an enable bit and a priority bit that puts it in the low or the high level. A global enable gates every source. The arbiter picks one winner by level and by a fixed order within the level. It presents a registered request and a registered vector address to the core. The core answers with an acknowledge when it takes the vector and a return pulse when a handler ends. Two in-service bits, one per level, let a high-level request preempt a low-level handler. A request never preempts a handler at its own level or at a higher one.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req` is 0, `irq_vec` is 0x0000 and neither level is in service.
- R2: Source index i gets vector 0x0003 + 8*i. The index order is ext pin 0 (i=0), timer 0 (i=1), ext pin 1 (i=2), timer 1 (i=3), serial (i=4), so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R3: Among eligible requests at the same level, the lowest index from R2 wins.
- R4: When both levels have eligible requests and nothing is in service, the high-level request wins. A source is high when its `src_hi` bit (bit i) is 1.
- R5: A source is eligible only when it is pending, its `src_en` bit i is 1 and `glb_en` is 1. Otherwise it never causes `irq_req`.
- R6: While the low level is in service, only high-level requests are raised. While the high level is in service, no request is raised.
- R7: When `irq_ack` is sampled high with `irq_req` high, `irq_req` is 0 in the next cycle and the winner's level becomes in service.
- R8: A pulse on `irq_ret` clears the high in-service bit if it is set, otherwise the low one. This releases requests that were held back.
- R9: The external pins are active-low and pass through a two-flop synchroniser. In level mode (`ext_edge` bit 0), `irq_req` follows a pin change on the third rising edge after it.
- R10: In edge mode (`ext_edge` bit 1), a falling edge latches a request. The request stays after the pin returns high, is cleared only when the core acknowledges that source, and a pin held low raises only one request.
- R11: The timer and serial flags are active-high and raise `irq_req` on the first rising edge after they are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 2 | Active-low external request pins |
| ext_edge | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| tmr_ovf | input | 2 | Timer overflow flags, active-high |
| ser_flag | input | 1 | Serial port flag, active-high |
| src_en | input | 5 | Per-source enable, indexed as in R2 |
| src_hi | input | 5 | Per-source priority, 1 = high level |
| glb_en | input | 1 | Global enable |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | 16 | Registered vector address of the winner |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_ret | input | 1 | Core finished the current handler |

## Verification
The bench first builds a low-level handler with a pending low source held back. It then checks that a high source breaks in and that a second high source waits. A design that compared levels wrongly would either start the same-level source or lose the preemption. It pulses `irq_ret` once with both levels in service and checks that only the high bit clears. A design that cleared both, or the low one, would start the waiting low handler too early. Edge-mode pins are checked with a one-cycle pulse and with a pin held low. A design that fed the raw level through, or never cleared the latch on acknowledge, would then drop the request or raise it twice. The tie-break order and the synchroniser latency are checked exactly against the R2 and R9 numbers.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);
  localparam int NEXT  = 2;
  // source positions in the fixed tie-break order
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
endpackage

// File: rtl/irq_ext_input.sv
module irq_ext_input #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic flag_q;
  logic pin_s;
  logic fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      if (!edge_mode)  flag_q <= 1'b0;
      else if (fall)   flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_s;

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    edge_mode && flag_q && !clr |=> flag_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic set_hi,
  input  logic ret,
  output logic ins_hi,
  output logic ins_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      if (ret) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
      if (set_en) begin
        if (set_hi) ins_hi <= 1'b1;
        else        ins_lo <= 1'b1;
      end
    end
  end

  // R8
  ret_hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    ret && !set_en && ins_hi |=> !ins_hi && (ins_lo == $past(ins_lo)));
  // R8
  ret_lo_chk: assert property (@(posedge clk) disable iff (rst)
    ret && !set_en && !ins_hi && ins_lo |=> !ins_lo);
  // R7
  set_level_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (set_hi ? ins_hi : ins_lo));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NEXT-1:0]       ext_irq_n,
  input  logic [NEXT-1:0]       ext_edge,
  input  logic [1:0]            tmr_ovf,
  input  logic                  ser_flag,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC-1:0]       src_hi,
  input  logic                  glb_en,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vec,
  input  logic                  irq_ack,
  input  logic                  irq_ret
);
  localparam int VEC_LAST = VEC_BASE + (NSRC - 1) * VEC_STEP;
  localparam int EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};

  logic [NEXT-1:0]  ext_req;
  logic [NEXT-1:0]  ext_clr;
  logic [NSRC-1:0]  pend, elig, cand_hi, cand_lo;
  logic             hit_hi, hit_lo;
  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic             ins_hi, ins_lo;
  logic             nxt_req, nxt_hi;
  logic [IDX_W-1:0] nxt_idx;
  logic             req_q, hi_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;
  logic             take;

  assign take = irq_ack & req_q;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_clr[g] = take && (idx_q == IDX_W'(EXT_IDX[g]));
    irq_ext_input #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk       (clk),
      .rst       (rst),
      .pin_n     (ext_irq_n[g]),
      .edge_mode (ext_edge[g]),
      .clr       (ext_clr[g]),
      .req       (ext_req[g])
    );
  end

  always_comb begin
    pend           = '0;
    pend[SRC_EXT0] = ext_req[0];
    pend[SRC_TMR0] = tmr_ovf[0];
    pend[SRC_EXT1] = ext_req[1];
    pend[SRC_TMR1] = tmr_ovf[1];
    pend[SRC_SER]  = ser_flag;
  end

  assign elig    = pend & src_en & {NSRC{glb_en}};
  assign cand_hi = elig & src_hi;
  assign cand_lo = elig & ~src_hi;

  irq_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick_hi (
    .cand (cand_hi), .hit (hit_hi), .idx (idx_hi)
  );
  irq_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick_lo (
    .cand (cand_lo), .hit (hit_lo), .idx (idx_lo)
  );

  always_comb begin
    nxt_req = 1'b0;
    nxt_hi  = 1'b0;
    nxt_idx = '0;
    if (!ins_hi && hit_hi) begin
      nxt_req = 1'b1;
      nxt_hi  = 1'b1;
      nxt_idx = idx_hi;
    end else if (!ins_hi && !ins_lo && hit_lo) begin
      nxt_req = 1'b1;
      nxt_idx = idx_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      hi_q  <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else begin
      req_q <= nxt_req;
      if (nxt_req) begin
        hi_q  <= nxt_hi;
        idx_q <= nxt_idx;
        vec_q <= VEC_W'(VEC_BASE + int'(nxt_idx) * VEC_STEP);
      end
    end
  end

  irq_level_track u_track (
    .clk    (clk),
    .rst    (rst),
    .set_en (take),
    .set_hi (hi_q),
    .ret    (irq_ret),
    .ins_hi (ins_hi),
    .ins_lo (ins_lo)
  );

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE)) && (irq_vec <= VEC_W'(VEC_LAST)));
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req);
  // R6
  hi_busy_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !ins_hi);
  // R6
  lo_busy_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && ins_lo |-> hi_q);
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_irq_n = 2'b11;
  logic [1:0]  ext_edge = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_flag = 1'b0;
  logic [4:0]  src_en = 5'h00;
  logic [4:0]  src_hi = 5'h00;
  logic        glb_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;
  logic m_hi = 1'b0;
  logic m_lo = 1'b0;

  always #4 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .src_en(src_en), .src_hi(src_hi),
    .glb_en(glb_en), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {ok, level, vector} from the requirements
  function automatic logic [17:0] model(input logic [4:0] pend, input logic [4:0] en,
      input logic [4:0] hi, input logic g, input logic mh, input logic ml);
    logic [4:0] el, ch, cl;
    int k;
    el = pend & en & {5{g}};
    ch = el & hi;
    cl = el & ~hi;
    k = 0;
    if (!mh && ch != 0) begin
      for (int i = 4; i >= 0; i--) if (ch[i]) k = i;
      return {1'b1, 1'b1, 16'(3 + 8 * k)};
    end else if (!mh && !ml && cl != 0) begin
      for (int i = 4; i >= 0; i--) if (cl[i]) k = i;
      return {1'b1, 1'b0, 16'(3 + 8 * k)};
    end
    return 18'h0;
  endfunction

  function automatic logic [4:0] pend_now();
    return {ser_flag, tmr_ovf[1], ~ext_irq_n[1], tmr_ovf[0], ~ext_irq_n[0]};
  endfunction

  task automatic check_model(input string tag);
    logic [17:0] e;
    e = model(pend_now(), src_en, src_hi, glb_en, m_hi, m_lo);
    chk(tag, {31'b0, irq_req}, {31'b0, e[17]});
    if (e[17]) chk(tag, {16'b0, irq_vec}, {16'b0, e[15:0]});
  endtask

  task automatic do_ack(input logic lvl);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    if (lvl) m_hi = 1'b1; else m_lo = 1'b1;
    chk("R7 req drops after ack", {31'b0, irq_req}, 32'd0);
  endtask

  task automatic do_ret();
    irq_ret = 1'b1;
    tick(1);
    irq_ret = 1'b0;
    if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [17:0] e;
    void'($urandom(32'h5A17));
    tick(3);
    rst = 1'b0;
    chk("R1 reset req", {31'b0, irq_req}, 32'd0);
    chk("R1 reset vec", {16'b0, irq_vec}, 32'd0);

    // R2: each source alone
    src_en = 5'h1F; glb_en = 1'b1; src_hi = 5'h00;
    for (int i = 0; i < 5; i++) begin
      ext_irq_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b0;
      case (i)
        0: ext_irq_n[0] = 1'b0;
        1: tmr_ovf[0] = 1'b1;
        2: ext_irq_n[1] = 1'b0;
        3: tmr_ovf[1] = 1'b1;
        default: ser_flag = 1'b1;
      endcase
      tick(4);
      chk("R2 vector", {16'b0, irq_vec}, 32'(3 + 8 * i));
      chk("R2 req", {31'b0, irq_req}, 32'd1);
    end

    // R3: tie-break within one level
    ext_irq_n = 2'b00; tmr_ovf = 2'b11; ser_flag = 1'b1;
    tick(4);
    chk("R3 all low", {16'b0, irq_vec}, 32'h03);
    ext_irq_n[0] = 1'b1;
    tick(4);
    chk("R3 next in order", {16'b0, irq_vec}, 32'h0B);

    // R4: high wins over lower index
    src_hi = 5'b10000;
    tick(1);
    chk("R4 high wins", {16'b0, irq_vec}, 32'h23);

    // R5: enables
    glb_en = 1'b0;
    tick(2);
    chk("R5 global off", {31'b0, irq_req}, 32'd0);
    glb_en = 1'b1; src_en = 5'h00;
    tick(2);
    chk("R5 sources off", {31'b0, irq_req}, 32'd0);
    src_en = 5'b01101;
    tick(2);
    chk("R5 partial enable", {16'b0, irq_vec}, 32'h13);

    // R6/R8 nesting
    ext_irq_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b1;
    src_en = 5'h1F; src_hi = 5'b01010;
    tick(4);
    chk("R6 low starts", {16'b0, irq_vec}, 32'h23);
    do_ack(1'b0);
    tick(2);
    chk("R6 same level waits", {31'b0, irq_req}, 32'd0);
    tmr_ovf[1] = 1'b1;
    tick(1);
    chk("R6 high preempts", {31'b0, irq_req}, 32'd1);
    chk("R6 high vector", {16'b0, irq_vec}, 32'h1B);
    do_ack(1'b1);
    tmr_ovf = 2'b01;
    tick(2);
    chk("R6 high waits for high", {31'b0, irq_req}, 32'd0);
    do_ret();
    tick(1);
    chk("R8 ret frees high", {16'b0, irq_vec}, 32'h0B);
    chk("R8 ret frees high req", {31'b0, irq_req}, 32'd1);
    tmr_ovf = 2'b00;
    tick(2);
    chk("R8 low still in service", {31'b0, irq_req}, 32'd0);
    do_ret();
    tick(1);
    chk("R8 second ret frees low", {16'b0, irq_vec}, 32'h23);
    do_ack(1'b0);
    ser_flag = 1'b0;
    do_ret();
    tick(2);

    // R9: synchroniser latency, level mode
    src_hi = 5'h00; src_en = 5'b00100;
    ext_irq_n[1] = 1'b0;
    tick(2);
    chk("R9 not before third edge", {31'b0, irq_req}, 32'd0);
    tick(1);
    chk("R9 third edge", {31'b0, irq_req}, 32'd1);
    chk("R9 vector", {16'b0, irq_vec}, 32'h13);
    ext_irq_n[1] = 1'b1;
    tick(3);
    chk("R9 follows pin high", {31'b0, irq_req}, 32'd0);

    // R10: edge mode
    src_en = 5'b00001; ext_edge = 2'b01;
    tick(2);
    ext_irq_n[0] = 1'b0;
    tick(1);
    ext_irq_n[0] = 1'b1;
    tick(5);
    chk("R10 latched after pulse", {31'b0, irq_req}, 32'd1);
    chk("R10 vector", {16'b0, irq_vec}, 32'h03);
    do_ack(1'b0);
    do_ret();
    tick(2);
    chk("R10 cleared by ack", {31'b0, irq_req}, 32'd0);
    ext_irq_n[0] = 1'b0;
    tick(5);
    chk("R10 held low raises", {31'b0, irq_req}, 32'd1);
    do_ack(1'b0);
    do_ret();
    tick(4);
    chk("R10 held low once", {31'b0, irq_req}, 32'd0);
    ext_irq_n[0] = 1'b1; ext_edge = 2'b00;
    tick(4);

    // R11: flag latency
    src_en = 5'b00010; tmr_ovf[0] = 1'b1;
    tick(1);
    chk("R11 one edge", {31'b0, irq_req}, 32'd1);
    chk("R11 vector", {16'b0, irq_vec}, 32'h0B);
    tmr_ovf = 2'b00;
    tick(2);

    // random: R3 R4 R5 R6 R7 R8 against model
    for (int it = 0; it < 400; it++) begin
      ext_irq_n = 2'($urandom);
      tmr_ovf   = 2'($urandom);
      ser_flag  = 1'($urandom);
      src_en    = 5'($urandom);
      src_hi    = 5'($urandom);
      glb_en    = ($urandom % 8) != 0;
      tick(4);
      check_model("R3/R4/R5/R6 random");
      e = model(pend_now(), src_en, src_hi, glb_en, m_hi, m_lo);
      case ($urandom % 4)
        0: if (e[17]) do_ack(e[16]);
        1: if (m_hi || m_lo) do_ret();
        default: ;
      endcase
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule